// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame passes the identifier filter and, if it does, which filter matched. The receiver presents the four identifier bytes of a completed frame, in bus order, together with a one-cycle frame strobe. Two 32-bit banks of acceptance code and acceptance mask bytes are compared against those bytes. A 2-bit mode field splits the banks into two, four or eight filters, or closes the filter altogether. One clock after the strobe, the block raises a single-cycle accept pulse and reports the number of the matching filter.

Byte k of every vector port sits at bits [8k+7:8k]. Inside a byte, bit 7 is the first bit on the bus. For an extended frame the identifier bytes are laid out as follows:
- byte 0 holds ID28..ID21;
- byte 1 holds ID20..ID18, SRR, IDE and ID17..ID15;
- byte 2 holds ID14..ID7;
- byte 3 holds ID6..ID0 and RTR.

For a standard frame, byte 0 holds ID10..ID3 and byte 1 holds ID2..ID0, RTR and IDE in bits 7..3. In both formats IDE is bit 3 of byte 1, which is `id_i[11]`; 1 means extended. Code bytes 0–3 form bank 0 and code bytes 4–7 form bank 1, and the mask bytes are arranged the same way.

Top module: `can_acf`

## Requirements
- R1: In mode 0 (`mode_i`=0) there are two 32-bit filters. Filter 0 compares code/mask bytes 0–3 with identifier bytes 0–3, and filter 1 does the same with bytes 4–7. For an extended frame all 32 bits take part.
- R2: For a standard frame (`id_i[11]`=0) in modes 0 and 1, only identifier byte 0 and bits 7..3 of byte 1 are compared. Bits 2..0 of byte 1, and bytes 2 and 3, never affect a match.
- R3: In mode 1 there are four 16-bit filters. Filter n compares code/mask bytes 2n (against identifier byte 0) and 2n+1 (against identifier byte 1). For an extended frame all 16 bits take part.
- R4: In mode 2 there are eight 8-bit filters. Filter n compares code/mask byte n against identifier byte 0 only.
- R5: In mode 3 no frame is ever accepted and the hit flag stays low.
- R6: A compared bit matches when the identifier bit equals the code bit, or when the mask bit is 1. A filter matches when every compared bit matches.
- R7: When several filters match, the lowest-numbered one is reported on `hit_idx_o`.
- R8: `accept_o` is high for exactly the one cycle after a strobed frame that matched. `hit_o` is updated one cycle after each strobe to show whether that frame matched, and holds between strobes.
- R9: A strobed frame that matches no filter gives no accept pulse and leaves `hit_idx_o` unchanged.
- R10: During reset, `accept_o`, `hit_o` and `hit_idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | One-cycle strobe: identifier bytes are valid |
| id_i | input | 32 | Received identifier bytes 0..3 |
| code_i | input | 64 | Acceptance code bytes 0..7 |
| mask_i | input | 64 | Acceptance mask bytes 0..7 (1 = don't care) |
| mode_i | input | 2 | 0: 2x32, 1: 4x16, 2: 8x8, 3: closed |
| accept_o | output | 1 | Accept pulse |
| hit_o | output | 1 | Last strobed frame matched |
| hit_idx_o | output | 3 | Index of the matching filter of the last accepted frame |

## Verification
The bench plants the identifier in a randomly chosen filter slot and also matches several slots at once, so a reversed priority encoder or a bank that is offset by a byte reports the wrong index. Standard frames have random contents in the bytes that should be ignored. A design that compares those bytes, or that reads the frame type from the wrong bit, rejects frames it should accept. Frames that match nothing follow accepted ones, which exposes an index that is not held and a closed mode that still accepts. The bench also checks the cycle after each result, which catches an accept output that is a level rather than a single pulse.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;
  typedef enum logic [1:0] {
    ACF_W32 = 2'd0,
    ACF_W16 = 2'd1,
    ACF_W8  = 2'd2,
    ACF_OFF = 2'd3
  } acf_mode_e;
  localparam int unsigned BANK_BYTES = 4;
  localparam int unsigned IDE_BIT    = 11;
endpackage

// File: rtl/can_acf_cmp.sv
module can_acf_cmp #(
  parameter int unsigned W = 1
) (
  input  logic [8*W-1:0] rx_i,
  input  logic [8*W-1:0] code_i,
  input  logic [8*W-1:0] mask_i,
  input  logic           std_i,
  output logic           hit_o
);
  // standard frame: byte 0 plus ID2..0, RTR, IDE of byte 1
  localparam logic [8*W-1:0] STD_CARE = (W == 1) ? '1 : (8*W)'(16'hF8FF);
  logic [8*W-1:0] care;
  assign care  = std_i ? STD_CARE : '1;
  assign hit_o = &(~(rx_i ^ code_i) | mask_i | ~care);
endmodule

// File: rtl/can_acf_prio.sv
module can_acf_prio #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/can_acf.sv
module can_acf
  import can_acf_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned NB = NUM_BANKS * BANK_BYTES,
  localparam int unsigned IW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_vld_i,
  input  logic [31:0]   id_i,
  input  logic [8*NB-1:0] code_i,
  input  logic [8*NB-1:0] mask_i,
  input  logic [1:0]    mode_i,
  output logic          accept_o,
  output logic          hit_o,
  output logic [IW-1:0] hit_idx_o
);
  logic          std_frame;
  logic [NB-1:0] hit_w [3];
  logic [NB-1:0] hit_sel;
  logic          any_hit;
  logic [IW-1:0] win_idx;
  acf_mode_e     mode;

  assign std_frame = ~id_i[IDE_BIT];
  assign mode      = acf_mode_e'(mode_i);

  // lw = 0: 8-bit, 1: 16-bit, 2: 32-bit filters
  for (genvar lw = 0; lw < 3; lw++) begin : g_width
    localparam int unsigned W  = 1 << lw;
    localparam int unsigned NF = NB / W;
    for (genvar f = 0; f < NB; f++) begin : g_flt
      if (f < NF) begin : g_on
        can_acf_cmp #(.W(W)) i_cmp (
          .rx_i  (id_i[8*W-1:0]),
          .code_i(code_i[8*W*f +: 8*W]),
          .mask_i(mask_i[8*W*f +: 8*W]),
          .std_i (std_frame),
          .hit_o (hit_w[lw][f])
        );
      end else begin : g_off
        assign hit_w[lw][f] = 1'b0;
      end
    end
  end

  always_comb begin
    unique case (mode)
      ACF_W32: hit_sel = hit_w[2];
      ACF_W16: hit_sel = hit_w[1];
      ACF_W8:  hit_sel = hit_w[0];
      default: hit_sel = '0;
    endcase
  end

  can_acf_prio #(.N(NB)) i_prio (
    .req_i(hit_sel),
    .any_o(any_hit),
    .idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o  <= 1'b0;
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
    end else begin
      accept_o <= frame_vld_i & any_hit;
      if (frame_vld_i) hit_o <= any_hit;
      if (frame_vld_i && any_hit) hit_idx_o <= win_idx;
    end
  end
endmodule

// File: rtl/can_acf_chk.sv
module can_acf_chk #(
  parameter int unsigned IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_vld_i,
  input logic [1:0]    mode_i,
  input logic          accept_o,
  input logic          hit_o,
  input logic [IW-1:0] hit_idx_o
);
  AST_CLOSED_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && mode_i == 2'd3) |=> (!accept_o && !hit_o)); // R5
  AST_ACCEPT_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(frame_vld_i)); // R8
  AST_ACCEPT_WITH_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> hit_o); // R8
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> $stable(hit_idx_o)); // R9
  AST_IDX_RANGE_W32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && mode_i == 2'd0) |=> (!accept_o || hit_idx_o < IW'(2))); // R1
  AST_IDX_RANGE_W16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && mode_i == 2'd1) |=> (!accept_o || hit_idx_o < IW'(4))); // R3
endmodule

bind can_acf can_acf_chk #(.IW(IW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_vld_i(frame_vld_i),
  .mode_i     (mode_i),
  .accept_o   (accept_o),
  .hit_o      (hit_o),
  .hit_idx_o  (hit_idx_o)
);

// File: tb/test_can_acf.sv
module test_can_acf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_vld_i = 1'b0;
  logic [31:0] id_i = '0;
  logic [63:0] code_i = '0;
  logic [63:0] mask_i = '0;
  logic [1:0]  mode_i = '0;
  logic        accept_o, hit_o;
  logic [2:0]  hit_idx_o;

  int tests = 0;
  int fails = 0;
  logic [2:0] exp_idx = '0;
  logic       exp_hit = 1'b0;

  always #2.5 clk_i = ~clk_i;

  can_acf i_can_acf (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference: returns {match, index}
  function automatic logic [3:0] ref_filter(logic [1:0] m, logic [31:0] id,
                                            logic [63:0] c, logic [63:0] k);
    int w, nf;
    logic ext;
    ext = id[11];
    if (m == 2'd3) return 4'b0;
    w  = (m == 2'd0) ? 4 : (m == 2'd1) ? 2 : 1;
    nf = 8 / w;
    for (int f = 0; f < nf; f++) begin
      logic ok;
      ok = 1'b1;
      for (int b = 0; b < 8 * w; b++) begin
        logic care;
        care = 1'b1;
        if (w >= 2 && !ext) care = (b < 8) || (b >= 11 && b < 16);
        if (care && !k[8*w*f + b] && (id[b] != c[8*w*f + b])) ok = 1'b0;
      end
      if (ok) return {1'b1, 3'(f)};
    end
    return 4'b0;
  endfunction

  task automatic run_frame(string req, logic [1:0] m, logic [31:0] id,
                           logic [63:0] c, logic [63:0] k);
    logic [3:0] r;
    r = ref_filter(m, id, c, k);
    @(negedge clk_i);
    mode_i = m; id_i = id; code_i = c; mask_i = k; frame_vld_i = 1'b1;
    @(negedge clk_i);
    frame_vld_i = 1'b0;
    exp_hit = r[3];
    if (r[3]) exp_idx = r[2:0];
    chk({req, " accept"}, 32'(accept_o), 32'(r[3]));
    chk({req, " hit"}, 32'(hit_o), 32'(exp_hit));
    chk({req, " idx"}, 32'(hit_idx_o), 32'(exp_idx));
    id_i = $urandom;
    @(negedge clk_i);
    chk("R8 pulse", 32'(accept_o), 32'd0);
    chk("R8 hold", 32'(hit_o), 32'(exp_hit));
  endtask

  initial begin
    logic [63:0] c, k;
    logic [31:0] id;
    void'($urandom(32'd4242));
    #1;
    chk("R10 accept", 32'(accept_o), 32'd0);
    chk("R10 hit", 32'(hit_o), 32'd0);
    chk("R10 idx", 32'(hit_idx_o), 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // directed cases
    id = 32'h1234_5E78;  // extended (bit 11 set)
    run_frame("R1 bank1", 2'd0, id, {id, ~id}, 64'h0);
    run_frame("R1 bank0", 2'd0, id, {~id, id}, 64'h0);
    run_frame("R7 all-mask", 2'd0, id, 64'h0, '1);
    run_frame("R9 nomatch", 2'd0, id, {~id, ~id}, 64'h0);
    id = 32'hAAAA_F0C3;  // standard: bit 11 clear
    run_frame("R2 std32", 2'd0, id, {32'h0, 16'h5555, id[15:11], 3'b111 ^ id[10:8], id[7:0]}, 64'h0);
    run_frame("R2 std16", 2'd1, id, {48'h0, id[15:11], ~id[10:8], id[7:0]}, 64'h0);
    run_frame("R3 f3", 2'd1, 32'h0000_0834, {16'h0834, 48'h0}, 64'h0);
    run_frame("R4 f5", 2'd2, 32'h0000_0899, {16'h0, 8'h99, 40'h0}, 64'h0);
    run_frame("R7 f2 over f5", 2'd2, 32'h0000_0899, {16'h0, 8'h99, 16'h0, 8'h99, 16'h0}, 64'h0);
    run_frame("R6 mask", 2'd2, 32'h0000_08F0, 64'h0F, 64'hF0);
    run_frame("R5 closed", 2'd3, id, 64'h0, '1);
    run_frame("R9 hold", 2'd2, 32'h0000_0801, 64'h0, 64'h0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [1:0] m;
      int w, f;
      m  = 2'($urandom_range(0, 3));
      id = $urandom;
      c  = {$urandom, $urandom};
      k  = {$urandom, $urandom} & {$urandom, $urandom};
      w  = (m == 2'd0) ? 4 : (m == 2'd1) ? 2 : 1;
      if ($urandom_range(0, 3) != 0) begin
        f = $urandom_range(0, 8 / w - 1);
        for (int b = 0; b < 8 * w; b++) c[8*w*f + b] = id[b];
      end
      if ($urandom_range(0, 3) == 0) begin
        f = $urandom_range(0, 8 / w - 1);
        for (int b = 0; b < 8 * w; b++) c[8*w*f + b] = id[b];
      end
      run_frame(id[11] ? "R6 rand ext" : "R2 rand std", m, id, c, k);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule